// File: doc/BRIEF.md
# Sparsity-Gated Successive-Approximation Controller

This block sequences the digital side of a successive-approximation converter that digitizes one column output of a compute-in-memory multiply-accumulate array. Each conversion request carries a digitized sparsity-sense value. The controller compares that value with a bank of programmable limits, one per candidate most-significant bit. The comparison tells it how many top result bits must be zero. Those bits are forced to zero and get no comparison cycle. Binary search then runs over the remaining low bits only. Each search step drives a trial code to an external DAC/comparator pair and reads back one decision bit.

A configuration pin selects the full precision per request, either the narrow width (3 bits by default) or the wide width (8 bits by default). The result carries the code and the number of comparison cycles spent. A sparse input therefore finishes in fewer cycles. A fully sparse input finishes with code zero and no trial at all.

Requests enter on a valid/ready channel and results leave on another. The input side is ready only while the controller is idle, and a request with valid raised while ready is low is not taken. The source keeps its request until ready is high. The result stays presented, unchanged, until the sink accepts it with ready. Until then the controller takes no new request. The limit registers, the mode pin and the comparator pins are plain control signals.

Top module: `sparse_sar_ctrl`

## Requirements
- R1: `cfg_wide`=0 at acceptance selects the narrow precision P=NARROW (3), and `cfg_wide`=1 selects P=WMAX (8). Codes are right-aligned in `res_code` and `dac_code`, and the bits at and above P are zero.
- R2: After reset, the limit for bit position k (k=1..WMAX, address k-1) is 2^(SW-1) shifted right by k-1. With SW=10 the limits are 512, 256, 128, 64, 32, 16, 8, 4.
- R3: The skip count S is the largest k in 1..P for which `in_sense` is strictly below limit k, or 0 when there is no such k. It uses the limits and the mode present at the acceptance edge.
- R4: The top S bits of the result are zero, and `res_cycles` equals P-S.
- R5: When S equals P, the result is code 0 with `res_cycles`=0. It is valid in the cycle after acceptance, and `dac_en` never rises for that request.
- R6: Each search step keeps its trial bit when `cmp_ge` is 1. For an integer input value v in LSB units, the code is 0 for v<0, v for 0<=v<2^(P-S), and 2^(P-S)-1 above that. This gives a negative-output clamp and saturation.
- R7: During each of the P-S search cycles `dac_en` is 1. `dac_code` then holds the bits already decided, plus a 1 at the bit under test and zeros below it. The bits are tested from the most significant remaining bit down. Outside those cycles `dac_en` is 0.
- R8: `in_ready` is 1 only while idle. A request with `in_valid` high while `in_ready` is 0 neither starts nor disturbs a conversion.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_code` and `res_cycles` hold steady. The controller returns to idle on the cycle after `res_valid` and `res_ready` are both high.
- R10: A write with `cfg_we`=1 replaces limit `cfg_addr`+1. It first affects a request accepted on a later edge, and a request accepted on the same edge still uses the old value.
- R11: During and right after reset, `in_ready`=1, `res_valid`=0 and `dac_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request present |
| in_ready | output | 1 | Controller idle and able to take a request |
| in_sense | input | SW | Digitized sparsity-sense value of the request |
| cfg_wide | input | 1 | Precision select, sampled on acceptance (1 = WMAX bits) |
| cfg_we | input | 1 | Limit write enable |
| cfg_addr | input | $clog2(WMAX) | Limit index (k-1) |
| cfg_data | input | SW | Limit value to write |
| dac_en | output | 1 | A trial code is being compared this cycle |
| dac_code | output | WMAX | Trial code for the DAC |
| cmp_ge | input | 1 | Comparator result: input at or above the trial |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result sink accepts |
| res_code | output | WMAX | Final code |
| res_cycles | output | $clog2(WMAX+1) | Comparison cycles used |

## Verification
Count cycles from an acceptance edge. Each of the next P-S cycles is a search cycle in which `dac_en` is high and `cmp_ge` is sampled at the end. In cycle P-S+1 `res_valid` rises, which is the first cycle after acceptance when S=P. The result then stays in place until the edge on which `res_ready` is seen high, and `in_ready` returns one cycle later. The bench reference model advances on the same rising edges from the same inputs. Every output is compared half a period later, so each expected value is taken in exactly the cycle it is due.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRCH = 2'd1,
    ST_DONE = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_limit_bank.sv
module sar_limit_bank #(
  parameter int WMAX   = 8,
  parameter int SW     = 10,
  parameter int NARROW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(WMAX)-1:0]    wr_addr,
  input  logic [SW-1:0]              wr_data,
  input  logic [SW-1:0]              sense,
  input  logic                       wide,
  output logic [$clog2(WMAX+1)-1:0]  prec_o,
  output logic [$clog2(WMAX+1)-1:0]  skip_o
);
  localparam int AW = $clog2(WMAX);
  localparam int CW = $clog2(WMAX+1);

  logic [SW-1:0] lim [WMAX];
  logic [WMAX-1:0] below;

  assign prec_o = wide ? CW'(WMAX) : CW'(NARROW);

  for (genvar g = 0; g < WMAX; g++) begin : g_lim
    localparam logic [SW-1:0] INIT = SW'((1 << (SW-1)) >> g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        lim[g] <= INIT;
      else if (wr_en && (wr_addr == AW'(g)))
        lim[g] <= wr_data;
    end
    assign below[g] = (sense < lim[g]) && (CW'(g) < prec_o);
  end

  // highest flagged position wins
  always_comb begin
    skip_o = '0;
    for (int k = 0; k < WMAX; k++)
      if (below[k]) skip_o = CW'(k + 1);
  end
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int WMAX = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       step,
  input  logic [$clog2(WMAX+1)-1:0]  prec_i,
  input  logic [$clog2(WMAX+1)-1:0]  skip_i,
  input  logic                       cmp_ge,
  output logic [WMAX-1:0]            trial,
  output logic [WMAX-1:0]            code,
  output logic [$clog2(WMAX+1)-1:0]  cycles,
  output logic                       last
);
  localparam int IW = (WMAX > 1) ? $clog2(WMAX) : 1;
  localparam int CW = $clog2(WMAX+1);

  logic [IW-1:0]   pos;
  logic [WMAX-1:0] probe;
  logic [CW-1:0]   top_pos;

  assign top_pos = prec_i - skip_i - CW'(1);
  assign probe   = WMAX'(1) << pos;
  assign trial   = code | probe;
  assign last    = (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code   <= '0;
      pos    <= '0;
      cycles <= '0;
    end else if (load) begin
      code   <= '0;
      pos    <= IW'(top_pos);
      cycles <= '0;
    end else if (step) begin
      if (cmp_ge) code <= code | probe;
      if (!last) pos <= pos - IW'(1);
      cycles <= cycles + CW'(1);
    end
  end
endmodule

// File: rtl/sparse_sar_ctrl.sv
module sparse_sar_ctrl #(
  parameter int WMAX   = 8,
  parameter int SW     = 10,
  parameter int NARROW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SW-1:0]              in_sense,
  input  logic                       cfg_wide,
  input  logic                       cfg_we,
  input  logic [$clog2(WMAX)-1:0]    cfg_addr,
  input  logic [SW-1:0]              cfg_data,
  output logic                       dac_en,
  output logic [WMAX-1:0]            dac_code,
  input  logic                       cmp_ge,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [WMAX-1:0]            res_code,
  output logic [$clog2(WMAX+1)-1:0]  res_cycles
);
  import sar_pkg::*;
  localparam int CW = $clog2(WMAX+1);

  sar_state_t    state;
  logic          accept;
  logic [CW-1:0] prec_w, skip_w, prec_q;
  logic [WMAX-1:0] trial;
  logic          last;

  assign in_ready  = (state == ST_IDLE);
  assign res_valid = (state == ST_DONE);
  assign dac_en    = (state == ST_SRCH);
  assign accept    = in_valid && in_ready;
  assign dac_code  = dac_en ? trial : '0;

  sar_limit_bank #(.WMAX(WMAX), .SW(SW), .NARROW(NARROW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .sense(in_sense), .wide(cfg_wide),
    .prec_o(prec_w), .skip_o(skip_w)
  );

  sar_search #(.WMAX(WMAX)) u_srch (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .step(dac_en),
    .prec_i(prec_w), .skip_i(skip_w),
    .cmp_ge(cmp_ge),
    .trial(trial), .code(res_code), .cycles(res_cycles), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      prec_q <= CW'(NARROW);
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          prec_q <= prec_w;
          state  <= (skip_w == prec_w) ? ST_DONE : ST_SRCH;
        end
        ST_SRCH: if (last) state <= ST_DONE;
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sparse_sar_chk.sv
module sparse_sar_chk #(
  parameter int WMAX = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       dac_en,
  input logic [WMAX-1:0]            dac_code,
  input logic                       res_valid,
  input logic                       res_ready,
  input logic [WMAX-1:0]            res_code,
  input logic [$clog2(WMAX+1)-1:0]  res_cycles,
  input logic [$clog2(WMAX+1)-1:0]  prec_q,
  input logic [$clog2(WMAX+1)-1:0]  prec_w,
  input logic [$clog2(WMAX+1)-1:0]  skip_w
);
  // R1
  narrow_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_code >> prec_q) == '0));
  // R4
  cycle_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cycles <= prec_q));
  // R5
  full_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (skip_w == prec_w)) |=>
      (res_valid && (res_code == '0) && (res_cycles == '0) && !dac_en));
  // R7
  trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_en |-> ((dac_code != '0) && !in_ready && !res_valid));
  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && res_valid));
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_code) && $stable(res_cycles)));
endmodule

bind sparse_sar_ctrl sparse_sar_chk #(.WMAX(WMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .dac_en(dac_en), .dac_code(dac_code), .res_valid(res_valid),
  .res_ready(res_ready), .res_code(res_code), .res_cycles(res_cycles),
  .prec_q(prec_q), .prec_w(prec_w), .skip_w(skip_w)
);

// File: tb/sim_sparse_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sparse_sar_ctrl;
  localparam int WMAX = 8, SW = 10, NARROW = 3;
  localparam int AW = $clog2(WMAX), CW = $clog2(WMAX+1);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, cfg_wide = 0, cfg_we = 0, res_ready = 1;
  logic [SW-1:0] in_sense = '0, cfg_data = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic in_ready, dac_en, res_valid, cmp_ge;
  logic [WMAX-1:0] dac_code, res_code;
  logic [CW-1:0] res_cycles;
  int ana = 0;

  always #4 clk = ~clk;
  assign cmp_ge = (ana >= int'(dac_code));

  sparse_sar_ctrl #(.WMAX(WMAX), .SW(SW), .NARROW(NARROW)) u0 (.*);

  int n_cmp = 0, n_bad = 0, wd = 0;
  string cur_tag = "R6";

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_phase = 0, m_left = 0, m_code = 0, m_cyc = 0;
  int m_thr [WMAX];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      for (int k = 0; k < WMAX; k++) m_thr[k] = (1 << (SW-1)) >> k;
    end else begin
      case (m_phase)
        0: if (in_valid) begin
          int p, sk, n, v;
          p = cfg_wide ? WMAX : NARROW;
          sk = 0;
          for (int k = 1; k <= p; k++)
            if (int'(in_sense) < m_thr[k-1]) sk = k;
          n = p - sk;
          v = ana;
          if (v < 0) v = 0;
          if (v > (1 << n) - 1) v = (1 << n) - 1;
          m_code = v; m_cyc = n; m_left = n;
          m_phase = (n == 0) ? 2 : 1;
        end
        1: begin m_left--; if (m_left == 0) m_phase = 2; end
        default: if (res_ready) m_phase = 0;
      endcase
      if (cfg_we && int'(cfg_addr) < WMAX) m_thr[cfg_addr] = int'(cfg_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 in_ready", int'(in_ready), int'(m_phase == 0));
      chk("R9 res_valid", int'(res_valid), int'(m_phase == 2));
      chk("R7 dac_en", int'(dac_en), int'(m_phase == 1));
      if (m_phase == 1) begin
        int b;
        b = m_left - 1;
        chk("R7 dac_code", int'(dac_code), ((m_code >> (b+1)) << (b+1)) | (1 << b));
      end
      if (m_phase == 2) begin
        chk({cur_tag, " res_code"}, int'(res_code), m_code);
        chk("R4 res_cycles", int'(res_cycles), m_cyc);
      end
    end
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic conv(string tag, int sense, bit wide, int a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_tag = tag;
    in_sense = SW'(sense); cfg_wide = wide; ana = a; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 in_ready", int'(in_ready), 1);
    chk("R11 res_valid", int'(res_valid), 0);
    chk("R11 dac_en", int'(dac_en), 0);
    rst_n = 1;
    // R1 narrow mode, R6 clamp and saturation, no skip
    conv("R6", 1000, 0, 5);
    conv("R6", 1000, 0, -2);
    conv("R6", 1000, 0, 9);
    conv("R1", 1000, 0, 7);
    // R3 narrow skips with default limits (R2): 300->1, 200->2, 100->3
    conv("R3", 300, 0, 2);
    conv("R3", 200, 0, 3);
    conv("R5", 100, 0, 6);
    // R1 wide mode
    conv("R1", 1000, 1, 173);
    conv("R6", 1000, 1, 300);
    // R2 boundaries: sense 4 -> skip 7, sense 3 -> skip 8
    conv("R2", 4, 1, 1);
    conv("R2", 4, 1, 5);
    conv("R5", 3, 1, 77);
    // R4 skip 3 in wide mode
    conv("R4", 100, 1, 20);
    conv("R4", 100, 1, 200);
    // R10 write limit k=6 on the same edge as an acceptance
    @(negedge clk);
    cur_tag = "R10";
    in_sense = 10'd100; cfg_wide = 1; ana = 20; in_valid = 1;
    cfg_we = 1; cfg_addr = 3'd5; cfg_data = 10'd1000;
    @(negedge clk);
    in_valid = 0; cfg_we = 0;
    while (!in_ready) @(negedge clk);
    conv("R10", 100, 1, 20);
    // R8 request held during a conversion
    @(negedge clk);
    cur_tag = "R8";
    in_sense = 10'd1000; cfg_wide = 1; ana = 90; in_valid = 1;
    @(negedge clk);
    in_sense = 10'd0; cfg_wide = 0;
    repeat (3) @(negedge clk);
    in_valid = 0;
    while (!in_ready) @(negedge clk);
    // R9 back-pressure
    res_ready = 0;
    conv_start: begin
      @(negedge clk);
      cur_tag = "R9";
      in_sense = 10'd1000; cfg_wide = 0; ana = 4; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
    end
    repeat (8) @(negedge clk);
    res_ready = 1;
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule